// File: doc/BRIEF.md
# Flash Program/Erase Suspend Arbiter

This block sits between the request side of a flash controller and its array sequencer. It decides when a program or erase operation may start. Several CPUs each own one suspend bit. While any of those bits is set, the block lets an operation that is already running finish. Any new program or erase request is held instead of started. Every CPU sees the same suspended flag, and that flag rises whether or not a request is waiting. Software can therefore test the flag before it issues a request.

When the last suspend bit drops, the flags clear and the held request is launched. Only one request can be held. A further request while one is held is dropped, and a one-cycle sequence-error pulse reports it. A request that arrives while an operation runs with no suspend active is held the same way, and it starts once the done pulse from the array timing model ends the running operation. The worst-case time from suspend to a quiet array is therefore one full operation time.

Top module: `flash_susp_arb`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, start_o, busy_o, seq_err_o and every bit of susp_flag_o are 0.
- R2: All bits of susp_flag_o carry one value. In each cycle it equals the OR of susp_req_i sampled at the previous clock edge. It rises even when no request is held.
- R3: With suspend flags low, busy_o low and nothing held, a request (op_req_i=1) gives start_o=1 for exactly one cycle at the next edge. In that cycle op_type_o equals the sampled op_type_i (0 program, 1 fast program, 2 page erase, 3 mass erase).
- R4: busy_o rises together with start_o. It stays high until the edge at which op_done_i is sampled high, including while suspend is active. op_done_i has no effect while busy_o is low.
- R5: A request sampled while susp_flag_o is high does not start. start_o stays 0 for as long as susp_flag_o stays high.
- R6: The held request starts with start_o=1 in the first cycle after susp_flag_o has returned to 0.
- R7: A request sampled while a request is already held is dropped. seq_err_o is 1 in the following cycle, and the dropped request never produces a start.
- R8: A request sampled while busy_o is high and suspend is low is held. It starts in the cycle after busy_o falls.
- R9: When a held request is started, op_type_o shows the type captured with that request and not the type of any later request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| susp_req_i | input | N_CPU | Suspend request, one bit per CPU |
| op_req_i | input | 1 | Program/erase request strobe |
| op_type_i | input | 2 | Type of the requested operation |
| op_done_i | input | 1 | Done pulse from the array timing model |
| op_start_o | output | 1 | One-cycle operation start pulse |
| op_type_o | output | 2 | Type of the started operation, valid with op_start_o |
| busy_o | output | 1 | Operation in progress |
| seq_err_o | output | 1 | One-cycle pulse when a request is dropped |
| susp_flag_o | output | N_CPU | Suspended status flag seen by each CPU |

## Verification
The bench builds the block with N_CPU=3. This puts one suspend bit inside the OR, not at its edges, so it can show that the flags stay up until every source has dropped, and it lets one CPU clear its bit while the other two still hold suspend. The operation type stays two bits wide, so the bench can start a held request with one type while a dropped request of a different type is presented. A cycle-by-cycle model compares every output on every clock. Directed checks cover suspend during a running operation, release timing, a request held behind a busy array, and the sequence-error drop.

// File: rtl/flash_susp_pkg.sv
package flash_susp_pkg;
  typedef enum logic [1:0] {
    OP_PROG       = 2'd0,
    OP_FAST_PROG  = 2'd1,
    OP_PAGE_ERASE = 2'd2,
    OP_MASS_ERASE = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic     valid;
    op_kind_e kind;
  } op_slot_t;
endpackage

// File: rtl/flash_susp_or_reg.sv
module flash_susp_or_reg #(
  parameter int N_CPU = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CPU-1:0] susp_req_i,
  output logic             susp_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) susp_q_o <= 1'b0;
    else         susp_q_o <= |susp_req_i;
  end
endmodule

// File: rtl/flash_susp_pend_slot.sv
module flash_susp_pend_slot
  import flash_susp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     capture_i,
  input  op_kind_e kind_i,
  input  logic     release_i,
  output op_slot_t slot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o <= '{valid: 1'b0, kind: OP_PROG};
    end else if (release_i) begin
      slot_o.valid <= 1'b0;
    end else if (capture_i) begin
      slot_o <= '{valid: 1'b1, kind: kind_i};
    end
  end
endmodule

// File: rtl/flash_susp_launch.sv
module flash_susp_launch
  import flash_susp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     launch_i,
  input  op_kind_e kind_i,
  input  logic     done_i,
  output logic     start_o,
  output op_kind_e kind_o,
  output logic     busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      kind_o  <= OP_PROG;
      busy_o  <= 1'b0;
    end else begin
      start_o <= launch_i;
      if (launch_i) begin
        kind_o <= kind_i;
        busy_o <= 1'b1;
      end else if (done_i) begin
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_susp_arb.sv
module flash_susp_arb
  import flash_susp_pkg::*;
#(
  parameter int N_CPU = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CPU-1:0] susp_req_i,
  input  logic             op_req_i,
  input  logic [1:0]       op_type_i,
  input  logic             op_done_i,
  output logic             op_start_o,
  output logic [1:0]       op_type_o,
  output logic             busy_o,
  output logic             seq_err_o,
  output logic [N_CPU-1:0] susp_flag_o
);
  logic     susp_q;
  op_slot_t slot;
  logic     can_launch, rel, direct, capture, launch;
  op_kind_e launch_kind, run_kind;

  flash_susp_or_reg #(.N_CPU(N_CPU)) u_or (
    .clk_i, .rst_ni, .susp_req_i, .susp_q_o(susp_q)
  );

  // gating uses the same registered suspend the CPUs observe
  always_comb begin
    can_launch  = !susp_q && !busy_o;
    rel         = slot.valid && can_launch;
    direct      = op_req_i && !slot.valid && can_launch;
    capture     = op_req_i && !slot.valid && !can_launch;
    launch      = rel || direct;
    launch_kind = rel ? slot.kind : op_kind_e'(op_type_i);
  end

  flash_susp_pend_slot u_slot (
    .clk_i, .rst_ni,
    .capture_i(capture),
    .kind_i(op_kind_e'(op_type_i)),
    .release_i(rel),
    .slot_o(slot)
  );

  flash_susp_launch u_launch (
    .clk_i, .rst_ni,
    .launch_i(launch),
    .kind_i(launch_kind),
    .done_i(op_done_i),
    .start_o(op_start_o),
    .kind_o(run_kind),
    .busy_o(busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seq_err_o <= 1'b0;
    else         seq_err_o <= op_req_i && slot.valid;
  end

  assign op_type_o = run_kind;

  for (genvar c = 0; c < N_CPU; c++) begin : g_flag
    assign susp_flag_o[c] = susp_q;
  end
endmodule

// File: rtl/flash_susp_arb_chk.sv
module flash_susp_arb_chk #(
  parameter int N_CPU = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CPU-1:0] susp_req_i,
  input logic             op_req_i,
  input logic             op_done_i,
  input logic             op_start_o,
  input logic             busy_o,
  input logic             seq_err_o,
  input logic [N_CPU-1:0] susp_flag_o
);
  AST_FLAGS_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(susp_flag_o) == 0) || ($countones(susp_flag_o) == N_CPU)); // R2
  AST_FLAG_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|susp_req_i) |=> susp_flag_o[0]); // R2
  AST_START_NOT_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> $past(susp_flag_o == '0)); // R5
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> busy_o); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !op_done_i) |=> busy_o); // R4
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !op_done_i) |=> !op_start_o); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> $past(op_req_i)); // R7
endmodule

bind flash_susp_arb flash_susp_arb_chk #(.N_CPU(N_CPU)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .susp_req_i(susp_req_i),
  .op_req_i(op_req_i), .op_done_i(op_done_i), .op_start_o(op_start_o),
  .busy_o(busy_o), .seq_err_o(seq_err_o), .susp_flag_o(susp_flag_o)
);

// File: tb/flash_susp_arb_test.sv
module flash_susp_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int WDOG = 5000;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] susp = '0;
  logic req = 0, done = 0;
  logic [1:0] typ = 0;
  logic start, busy, err;
  logic [1:0] otyp;
  logic [N-1:0] flag;

  int errors = 0, checks = 0, cyc = 0;
  bit fin = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_susp_arb #(.N_CPU(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .susp_req_i(susp), .op_req_i(req),
    .op_type_i(typ), .op_done_i(done), .op_start_o(start), .op_type_o(otyp),
    .busy_o(busy), .seq_err_o(err), .susp_flag_o(flag)
  );

  // behavioural reference
  bit m_susp, m_pv, m_start, m_busy, m_err;
  int m_pt, m_type;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_susp <= 0; m_pv <= 0; m_start <= 0; m_busy <= 0; m_err <= 0;
      m_pt <= 0; m_type <= 0;
    end else begin
      bit ok;
      ok = !m_susp && !m_busy;
      m_err   <= req && m_pv;
      m_start <= 0;
      if (m_busy && done) m_busy <= 0;
      if (m_pv && ok) begin
        m_start <= 1; m_type <= m_pt; m_busy <= 1; m_pv <= 0;
      end else if (req && !m_pv) begin
        if (ok) begin m_start <= 1; m_type <= int'(typ); m_busy <= 1; end
        else begin m_pv <= 1; m_pt <= int'(typ); end
      end
      m_susp <= (susp != 0);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !fin) begin
    check(start == m_start, "R3 start vs model", int'(start), int'(m_start));
    check(busy == m_busy, "R4 busy vs model", int'(busy), int'(m_busy));
    check(err == m_err, "R7 seq_err vs model", int'(err), int'(m_err));
    check(flag == {N{m_susp}}, "R2 flags vs model", int'(flag), m_susp ? (1<<N)-1 : 0);
    if (m_start) check(int'(otyp) == m_type, "R9 type vs model", int'(otyp), m_type);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !fin) begin
      fin = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input int t);
    req = 1; typ = 2'(t); step(); req = 0;
  endtask

  initial begin
    step(2);
    check(!start && !busy && !err && flag == 0, "R1 in reset", int'({start, busy, err}), 0);
    rst_n = 1;
    step();
    check(!start && !busy && !err && flag == 0, "R1 after reset", int'({start, busy, err}), 0);

    // direct start
    request(1);
    check(start && otyp == 2'd1, "R3 direct start", int'(otyp), 1);
    step();
    check(!start && busy, "R3 single pulse", int'(start), 0);
    done = 1; step(); done = 0;
    check(!busy, "R4 done ends busy", int'(busy), 0);
    done = 1; step(); done = 0;
    check(!busy && !start, "R4 stray done ignored", int'(busy), 0);

    // flags with nothing pending
    susp = 3'b010; step();
    check(flag == 3'b111, "R2 flags set without request", int'(flag), 7);
    request(2);
    check(!start, "R5 held under suspend", int'(start), 0);
    step(3);
    check(!start && !busy, "R5 still held", int'(start), 0);
    susp = 3'b011; step(); susp = 3'b001; step();
    check(flag == 3'b111, "R2 one source still set", int'(flag), 7);
    susp = 0; step();
    check(flag == 0 && !start, "R6 flags clear first", int'(start), 0);
    step();
    check(start && otyp == 2'd2, "R6 release start", int'(otyp), 2);

    // suspend during running op, then held + dropped
    susp = 3'b100; step(2);
    check(busy, "R4 running op not aborted", int'(busy), 1);
    request(3);
    request(0);
    check(err, "R7 second request dropped", int'(err), 1);
    step();
    check(!err, "R7 pulse one cycle", int'(err), 0);
    done = 1; step(); done = 0;
    check(!busy && !start, "R5 no start after done under suspend", int'(start), 0);
    susp = 0; step(2);
    check(start && otyp == 2'd3, "R9 held type kept", int'(otyp), 3);
    step(); done = 1; step(); done = 0; step(3);
    check(!start && !busy, "R7 dropped never starts", int'(start), 0);

    // request behind busy array
    request(0);
    step();
    request(2);
    check(!start && busy, "R8 held behind busy", int'(start), 0);
    step(2);
    done = 1; step(); done = 0;
    check(!busy, "R8 busy fell", int'(busy), 0);
    step();
    check(start && otyp == 2'd2, "R8 start after busy falls", int'(otyp), 2);
    done = 1; step(); done = 0;
    step(3);

    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule